// File: doc/BRIEF.md
# Second-Order Mismatch-Shaping Element Selector

This block drives a bank of 24 identical unit elements in a multi-level converter. Each modulator sample is a signed code from -12 to +12. The block turns it into a 24-bit enable vector in which exactly `code + 12` bits are set. The block does not fix which elements carry the code. It chooses them so that the error caused by element mismatch is shaped to second order and moved out of the signal band.

Each element keeps two cascaded usage accumulators. The first integrates the element's usage minus the mean usage of the sample. The second integrates the first. Elements with the lowest second-stage value are preferred. A full sort over 24 elements would cost too much, so only an 8-element window that starts at a rotating pointer is ranked. Any elements still needed after the window are taken in rotation order after it. The pointer then advances by the number of elements used. The second-stage values saturate at a fixed width, and every few samples they are shifted down by their minimum.

Samples enter on a valid/ready stream and leave on a valid/ready stream with one register stage. A sample is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds and no new sample is accepted.

Top module: `dem2_selector`

## Requirements
- R1: After reset `out_valid` and `out_en` are 0 and `in_ready` is 1. All usage states clear to zero and the pointer returns to element 0.
- R2: Every output vector has a popcount equal to the clamped code plus 12.
- R3: `in_code` is 5-bit two's complement. Codes above +12 are treated as +12 and codes below -12 are treated as -12.
- R4: Code +12 enables all 24 elements (`out_en` = 24'hFFFFFF). Code -12 enables none.
- R5: `in_ready` equals `!out_valid || out_ready`. An accepted sample appears on `out_en` with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_en` stay unchanged.
- R6: Ties in usage state are broken by rotation order from the pointer. The first sample after reset with count n therefore enables elements 0 to n-1, where bit i of `out_en` is element i.
- R7: After each accepted sample the pointer advances by the count, modulo 24. After reset, three samples of code -4 give 24'h0000FF, 24'h00FF00 and 24'hFF0000.
- R8: With a count of 8 or less, only elements in the 8-slot window from the pointer are enabled, and the ones with the lowest second-stage state are chosen first. After reset, codes -4, +8 and -10 give 24'h0000FF, 24'hFFFF0F and 24'h000300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_code | input | 5 | Signed level code |
| out_valid | output | 1 | Enable vector valid |
| out_ready | input | 1 | Downstream accepts the vector |
| out_en | output | 24 | Per-element enable vector |

## Verification
The hardest case to reach from the ports is a window whose elements hold unequal second-stage states, because only that case shows the least-used preference at work. Random traffic produces such windows, but the outcome cannot be predicted without modelling the whole state. The bench therefore starts from reset and drives a short sequence whose state can be worked out by hand: a full window, then a large count that wraps past element 23, then a count of 2. That sequence leaves a window that straddles two usage groups, with the less-used group in the window's second half. Random stimulus with stalls and out-of-range codes then checks count and hold behaviour over a long run.

// File: rtl/dem2_pkg.sv
package dem2_pkg;

  // Clamp a signed integer into the range of a w-bit two's complement value.
  function automatic int sat_to_width(input int v, input int w);
    int lo;
    int hi;
    lo = -(1 <<< (w - 1));
    hi = (1 <<< (w - 1)) - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Ring index wrap: (base + off) mod n, assuming base < n and off < n.
  function automatic int ring_add(input int base, input int off, input int n);
    int t;
    t = base + off;
    if (t >= n) t = t - n;
    return t;
  endfunction

endpackage

// File: rtl/dem2_window_rank.sv
module dem2_window_rank #(
  parameter int WIN   = 8,
  parameter int S_W   = 14,
  parameter int CNT_W = 5
) (
  input  logic [WIN-1:0][S_W-1:0] win_s,
  input  logic [CNT_W-1:0]        n_take,
  output logic [WIN-1:0]          win_sel
);

  // Each slot counts how many slots beat it: a lower state, or an equal
  // state at an earlier slot. Ranks are distinct, so the first n_take ranks
  // give exactly min(n_take, WIN) selected slots.
  for (genvar i = 0; i < WIN; i++) begin : g_slot
    logic [CNT_W-1:0] rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < WIN; j++) begin
        if (j != i) begin
          if ($signed(win_s[j]) < $signed(win_s[i]))
            rank = rank + 1'b1;
          else if (($signed(win_s[j]) == $signed(win_s[i])) && (j < i))
            rank = rank + 1'b1;
        end
      end
    end
    assign win_sel[i] = (rank < n_take);
  end

endmodule

// File: rtl/dem2_usage_bank.sv
module dem2_usage_bank
  import dem2_pkg::*;
#(
  parameter int N_ELEM       = 24,
  parameter int S1_W         = 10,
  parameter int S2_W         = 14,
  parameter int CNT_W        = 5,
  parameter int REBASE_EVERY = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd,
  input  logic [N_ELEM-1:0]           en_vec,
  input  logic [CNT_W-1:0]            n_used,
  output logic [N_ELEM-1:0][S2_W-1:0] s2_out
);

  localparam int RB_W = (REBASE_EVERY > 2) ? $clog2(REBASE_EVERY) : 1;

  logic [RB_W-1:0] rb_cnt;
  logic            rebase;
  logic [S2_W-1:0] s2_min;

  assign rebase = (int'(rb_cnt) == REBASE_EVERY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_cnt <= '0;
    end else if (upd) begin
      if (rebase) rb_cnt <= '0;
      else        rb_cnt <= rb_cnt + 1'b1;
    end
  end

  // Minimum of the stored second-stage states, used for the rebase shift.
  always_comb begin
    s2_min = s2_out[0];
    for (int e = 1; e < N_ELEM; e++) begin
      if ($signed(s2_out[e]) < $signed(s2_min)) s2_min = s2_out[e];
    end
  end

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    logic [S1_W-1:0] s1_q;
    logic [S2_W-1:0] s2_q;
    int              s1_nx;
    int              s2_nx;

    always_comb begin
      // Scaled by N_ELEM so that the mean usage stays an integer.
      s1_nx = sat_to_width(int'($signed(s1_q)) + (en_vec[e] ? N_ELEM : 0)
                           - int'(n_used), S1_W);
      s2_nx = int'($signed(s2_q)) + s1_nx;
      if (rebase) s2_nx = s2_nx - int'($signed(s2_min));
      s2_nx = sat_to_width(s2_nx, S2_W);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q <= '0;
        s2_q <= '0;
      end else if (upd) begin
        s1_q <= S1_W'(s1_nx);
        s2_q <= S2_W'(s2_nx);
      end
    end

    assign s2_out[e] = s2_q;
  end

endmodule

// File: rtl/dem2_selector.sv
module dem2_selector
  import dem2_pkg::*;
#(
  parameter int N_ELEM       = 24,
  parameter int WIN          = 8,
  parameter int CODE_W       = 5,
  parameter int S1_W         = 10,
  parameter int S2_W         = 14,
  parameter int REBASE_EVERY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [N_ELEM-1:0] out_en
);

  localparam int HALF  = N_ELEM / 2;
  localparam int PTR_W = $clog2(N_ELEM);
  localparam int CNT_W = $clog2(N_ELEM + 1);

  logic                        accept;
  logic [CNT_W-1:0]            n_req;
  logic [PTR_W-1:0]            ptr;
  logic [N_ELEM-1:0][S2_W-1:0] s2_all;
  logic [WIN-1:0][S2_W-1:0]    win_s;
  logic [WIN-1:0]              win_sel;
  logic [N_ELEM-1:0]           en_next;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // Clamp the signed code into the legal level range, then offset it to a count.
  always_comb begin
    int c;
    c = int'($signed(in_code));
    if (c > HALF)  c = HALF;
    if (c < -HALF) c = -HALF;
    n_req = CNT_W'(c + HALF);
  end

  // Gather the window of states starting at the pointer.
  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      win_s[i] = s2_all[ring_add(int'(ptr), i, N_ELEM)];
    end
  end

  dem2_window_rank #(
    .WIN   (WIN),
    .S_W   (S2_W),
    .CNT_W (CNT_W)
  ) u_rank (
    .win_s   (win_s),
    .n_take  (n_req),
    .win_sel (win_sel)
  );

  // Ranked window slots first, then rotation-order fill beyond the window.
  always_comb begin
    en_next = '0;
    for (int k = 0; k < N_ELEM; k++) begin
      if (k < WIN) en_next[ring_add(int'(ptr), k, N_ELEM)] = win_sel[k];
      else         en_next[ring_add(int'(ptr), k, N_ELEM)] = (k < int'(n_req));
    end
  end

  dem2_usage_bank #(
    .N_ELEM       (N_ELEM),
    .S1_W         (S1_W),
    .S2_W         (S2_W),
    .CNT_W        (CNT_W),
    .REBASE_EVERY (REBASE_EVERY)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (accept),
    .en_vec (en_next),
    .n_used (n_req),
    .s2_out (s2_all)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      out_valid <= 1'b0;
      out_en    <= '0;
    end else begin
      if (accept) begin
        ptr    <= PTR_W'(ring_add(int'(ptr), int'(n_req) % N_ELEM, N_ELEM));
        out_en <= en_next;
      end
      if (accept)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($countones(en_next) == int'(n_req))); // R2

  AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && int'(n_req) == N_ELEM) |-> (&en_next)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_en))); // R5

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < N_ELEM); // R7

  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && int'(n_req) <= WIN) |-> ($countones(win_sel) == int'(n_req))); // R8

endmodule

// File: tb/dem2_selector_tb.sv
module dem2_selector_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [4:0]  in_code;
  logic        out_valid;
  logic        out_ready;
  logic [23:0] out_en;

  int checks = 0;
  int errors = 0;

  int           q_cnt[$];
  bit           q_hasx[$];
  logic [23:0]  q_vec[$];
  string        q_req[$];

  bit          hold_pend = 1'b0;
  logic [23:0] hold_vec;

  always #2.5 clk = ~clk;

  dem2_selector u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_code   (in_code),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_en    (out_en)
  );

  function automatic int exp_count(input logic [4:0] c);
    int v;
    v = int'($signed(c));
    if (v > 12)  v = 12;
    if (v < -12) v = -12;
    return v + 12;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One cycle: drive at the falling edge, observe, then wait for the rising edge.
  task automatic step(input bit v, input logic [4:0] code, input bit rdy,
                      input bit hasx, input logic [23:0] xv, input string rq,
                      output bit fired);
    @(negedge clk);
    in_valid  = v;
    in_code   = code;
    out_ready = rdy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R5", "in_ready rule",
          in_ready, !out_valid || out_ready);
    if (hold_pend) begin
      check(out_valid && out_en == hold_vec, "R5", "stall hold", out_en, hold_vec);
      hold_pend = 1'b0;
    end
    if (out_valid && !out_ready) begin
      hold_pend = 1'b1;
      hold_vec  = out_en;
    end
    if (out_valid && out_ready) begin
      if (q_cnt.size() == 0) begin
        check(1'b0, "R5", "unexpected output", out_en, 0);
      end else begin
        int          ec;
        bit          hx;
        logic [23:0] ev;
        string       rr;
        ec = q_cnt.pop_front();
        hx = q_hasx.pop_front();
        ev = q_vec.pop_front();
        rr = q_req.pop_front();
        check($countones(out_en) == ec, "R2", "popcount", $countones(out_en), ec);
        if (hx) check(out_en == ev, rr, "vector", out_en, ev);
      end
    end
    fired = v && in_ready;
    if (fired) begin
      q_cnt.push_back(exp_count(code));
      q_hasx.push_back(hasx);
      q_vec.push_back(xv);
      q_req.push_back(rq);
    end
  endtask

  task automatic send(input logic [4:0] code, input bit hasx,
                      input logic [23:0] xv, input string rq);
    bit f;
    f = 1'b0;
    while (!f) step(1'b1, code, 1'b1, hasx, xv, rq, f);
  endtask

  task automatic drain();
    bit f;
    for (int i = 0; i < 4; i++) step(1'b0, 5'd0, 1'b1, 1'b0, '0, "R5", f);
    check(q_cnt.size() == 0, "R5", "all samples delivered", q_cnt.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_code   = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    q_cnt.delete();
    q_hasx.delete();
    q_vec.delete();
    q_req.delete();
    hold_pend = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_en == '0, "R1", "out_en after reset", out_en, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_code = '0;
    out_ready = 1'b0;

    // R1, R6: first sample after reset fills elements from 0 upward
    do_reset();
    send(5'sd3, 1'b1, 24'h007FFF, "R6");
    drain();

    // R7: equal windows advance the pointer by the count and wrap
    do_reset();
    send(-5'sd4, 1'b1, 24'h0000FF, "R7");
    send(-5'sd4, 1'b1, 24'h00FF00, "R7");
    send(-5'sd4, 1'b1, 24'hFF0000, "R7");
    drain();

    // R8: less-used half of a straddling window wins
    do_reset();
    send(-5'sd4, 1'b1, 24'h0000FF, "R8");
    send(5'sd8,  1'b1, 24'hFFFF0F, "R8");
    send(-5'sd10, 1'b1, 24'h000300, "R8");
    drain();

    // R3, R4: end levels and clamping of out-of-range codes
    do_reset();
    send(5'sd12,  1'b1, 24'hFFFFFF, "R4");
    send(-5'sd12, 1'b1, 24'h000000, "R4");
    send(5'b01111, 1'b1, 24'hFFFFFF, "R3");
    send(5'b10000, 1'b1, 24'h000000, "R3");
    send(5'sd13,  1'b1, 24'hFFFFFF, "R3");
    send(5'b10011, 1'b1, 24'h000000, "R3");
    drain();

    // R2, R5: random codes with random back-pressure
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      bit f;
      step(($urandom % 4) != 0, 5'($urandom), ($urandom % 3) != 0,
           1'b0, '0, "R2", f);
    end
    drain();

    // R2: long stretch of small codes exercising the window and rebase
    for (int i = 0; i < 1000; i++) begin
      bit f;
      step(1'b1, 5'(int'($urandom % 9) - 12), 1'b1, 1'b0, '0, "R2", f);
    end
    drain();

    summary();
  end

endmodule